// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block sits between the status logic of a 16550-style serial port and the host CPU. It collects five interrupt sources into one level-sensitive interrupt line and an identification byte that the host reads to learn which source to service first. The sources are receive-path errors, a character timeout, receive data available, transmit holding register empty, and modem-status changes. The FIFO storage, the serializer and the baud generator are outside the block; only their status flags come in.

The host reaches the block through a small byte-wide register bus. Offset 0 is the transmit data register, and the block only uses the fact that it was written. Offset 1 is the interrupt enable register, which can be written and read. Offset 2 is the identification register, which can be read. Reading the identification register acknowledges a transmit-empty interrupt. Writing transmit data also withdraws it. Writing the enable register while the holding register is empty re-arms it. The identification byte and the interrupt line are registered, so they settle one clock after any change in the sources.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the identification byte is 0x01, the enable register reads 0 and the interrupt line is low.
- R2: A bus write to offset 1 stores bits 3:0 of the write data in the enable register and drops bits 7:4. The enable bits are: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line errors, bit 3 modem status.
- R3: When enable bit 2 is set and any of the four line error flags is set, the identification code (bits 3:0) is 0x6. This source outranks every other source.
- R4: The character-timeout source gives code 0xC. It is enabled only by enable bit 0, and it ranks above receive data.
- R5: The receive-data source gives code 0x4 when enable bit 0 is set and data is ready. In FIFO mode it also needs the receive count to be at or above the trigger level.
- R6: The transmit-empty source gives code 0x2 when enable bit 1 is set and the internal pending flag is set. The modem source gives code 0x0 when enable bit 3 is set and any delta flag is set. Transmit empty ranks above modem status.
- R7: A transmit-drained event sets the pending flag. A write to offset 0 clears it and overrides any set in the same cycle. A write to offset 1 while the holding register is empty sets it.
- R8: A read of offset 2 clears the pending flag only while the identification code being read is 0x2. A read that returns any other code leaves the flag unchanged.
- R9: Identification bits 7:6 are 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 are always 0.
- R10: The interrupt line is high exactly when the code is not 0x1. It changes on the first clock edge after a source input changes.
- R11: With no enabled source active, the code is 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register offset |
| busWrData | input | 8 | Write data |
| lineErr | input | 4 | Overrun, parity, framing and break flags |
| dataReady | input | 1 | Receive data ready |
| rxCount | input | CNT_W | Receive FIFO fill count |
| trigLevel | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| thrEmpty | input | 1 | Transmit holding register empty (level) |
| txEmptyEvt | input | 1 | Pulse: holding register has just drained |
| msDelta | input | 4 | Modem status delta flags |
| fifoEn | input | 1 | FIFO mode enabled |
| iirOut | output | 8 | Identification byte |
| ierOut | output | 4 | Enable register readback |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with the default FIFO depth of 16, which gives a 5-bit count. This lets it drive every trigger level a 16550-style port uses (1, 4, 8, 14) and also a full count of 16. The boundary where the count sits one below the trigger level and then exactly at it is therefore reachable. So is a count above the trigger. With the small enable register, random traffic also covers every masking combination, including the case where the timeout source is masked along with receive data.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 5;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_IER  = 3'd1;
  localparam logic [2:0] ADDR_IIR  = 3'd2;

  localparam logic [3:0] ID_LINE  = 4'h6;
  localparam logic [3:0] ID_TMO   = 4'hC;
  localparam logic [3:0] ID_RX    = 4'h4;
  localparam logic [3:0] ID_TX    = 4'h2;
  localparam logic [3:0] ID_MODEM = 4'h0;
  localparam logic [3:0] ID_NONE  = 4'h1;

  typedef struct packed {
    logic ierWr;
    logic thrWr;
    logic iirRd;
  } strobe_t;

  // Index 0 is the highest priority.
  function automatic logic [3:0] srcCode(input int idx);
    case (idx)
      0:       srcCode = ID_LINE;
      1:       srcCode = ID_TMO;
      2:       srcCode = ID_RX;
      3:       srcCode = ID_TX;
      default: srcCode = ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic       busWr,
  input  logic       busRd,
  input  logic [2:0] busAddr,
  output strobe_t    strb
);

  always_comb begin
    strb.thrWr = busWr && (busAddr == ADDR_DATA);
    strb.ierWr = busWr && (busAddr == ADDR_IER);
    strb.iirRd = busRd && (busAddr == ADDR_IIR);
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       wrData,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic             thrEmpty,
  input  logic             txEmptyEvt,
  input  logic [3:0]       msDelta,
  input  logic             fifoEn,
  output logic [7:0]       iirOut,
  output logic [3:0]       ierOut,
  output logic             irq
);

  logic [3:0]         ierQ;
  logic               txPend;
  logic [7:0]         iirQ;
  logic               irqQ;
  logic [NUM_SRC-1:0] srcReq;
  logic [3:0]         idNext;
  logic               unusedHi;

  assign unusedHi = ^wrData[7:4];

  // Enable register
  always_ff @(posedge clk) begin
    if (!rstN)           ierQ <= '0;
    else if (strb.ierWr) ierQ <= wrData[3:0];
  end

  // Transmit-empty pending flag
  always_ff @(posedge clk) begin
    if (!rstN)                                txPend <= 1'b0;
    else if (strb.thrWr)                      txPend <= 1'b0;
    else if (txEmptyEvt || (strb.ierWr && thrEmpty)) txPend <= 1'b1;
    else if (strb.iirRd && iirQ[3:0] == ID_TX) txPend <= 1'b0;
  end

  // Source requests, index 0 highest
  always_comb begin
    srcReq[0] = ierQ[2] && (|lineErr);
    srcReq[1] = ierQ[0] && timeoutPend;
    srcReq[2] = ierQ[0] && dataReady && (!fifoEn || (rxCount >= trigLevel));
    srcReq[3] = ierQ[1] && txPend;
    srcReq[4] = ierQ[3] && (|msDelta);
  end

  always_comb begin
    idNext = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcReq[i]) idNext = srcCode(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iirQ <= {4'h0, ID_NONE};
      irqQ <= 1'b0;
    end else begin
      iirQ <= {{2{fifoEn}}, 2'b00, idNext};
      irqQ <= (idNext != ID_NONE);
    end
  end

  assign iirOut = iirQ;
  assign ierOut = ierQ;
  assign irq    = irqQ;

  assert_ier_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ierWr |=> ierQ == $past(wrData[3:0]));

  assert_line_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ[2] && (|lineErr)) |=> iirQ[3:0] == ID_LINE);

  assert_thr_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.thrWr |=> !txPend);

  assert_iir_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.iirRd && iirQ[3:0] == ID_TX && !txEmptyEvt && !strb.ierWr) |=> !txPend);

  assert_fifo_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoEn |=> iirQ[7:4] == 4'hC);

  assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idNext != ID_NONE) |=> irq);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [2:0]       busAddr,
  input  logic [7:0]       busWrData,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic             thrEmpty,
  input  logic             txEmptyEvt,
  input  logic [3:0]       msDelta,
  input  logic             fifoEn,
  output logic [7:0]       iirOut,
  output logic [3:0]       ierOut,
  output logic             irq
);

  strobe_t strb;

  uart_irq_ctrl u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .strb    (strb)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .lineErr     (lineErr),
    .dataReady   (dataReady),
    .rxCount     (rxCount),
    .trigLevel   (trigLevel),
    .timeoutPend (timeoutPend),
    .thrEmpty    (thrEmpty),
    .txEmptyEvt  (txEmptyEvt),
    .msDelta     (msDelta),
    .fifoEn      (fifoEn),
    .iirOut      (iirOut),
    .ierOut      (ierOut),
    .irq         (irq)
  );

endmodule

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;

  localparam int CW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 0, busRd = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWrData = 0;
  logic [3:0] lineErr = 0;
  logic dataReady = 0;
  logic [CW-1:0] rxCount = 0, trigLevel = 1;
  logic timeoutPend = 0, thrEmpty = 0, txEmptyEvt = 0, fifoEn = 0;
  logic [3:0] msDelta = 0;
  logic [7:0] iirOut;
  logic [3:0] ierOut;
  logic irq;

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [3:0] mIer = 0;
  bit mTx = 0;

  always #5 clk = ~clk;

  uart_irq_arbiter u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .lineErr(lineErr), .dataReady(dataReady),
    .rxCount(rxCount), .trigLevel(trigLevel), .timeoutPend(timeoutPend),
    .thrEmpty(thrEmpty), .txEmptyEvt(txEmptyEvt), .msDelta(msDelta),
    .fifoEn(fifoEn), .iirOut(iirOut), .ierOut(ierOut), .irq(irq)
  );

  function automatic logic [3:0] refId();
    if (mIer[2] && |lineErr) return 4'h6;
    if (mIer[0] && timeoutPend) return 4'hC;
    if (mIer[0] && dataReady && (!fifoEn || rxCount >= trigLevel)) return 4'h4;
    if (mIer[1] && mTx) return 4'h2;
    if (mIer[3] && |msDelta) return 4'h0;
    return 4'h1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    logic [3:0] id = refId();
    chk(req, iirOut, {{2{fifoEn}}, 2'b00, id});
    chk(req, {7'd0, irq}, {7'd0, id != 4'h1});
    chk(req, {4'd0, ierOut}, {4'd0, mIer});
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // op: 0 none, 1 ier write, 2 thr write, 3 iir read, 4 drained event
  task automatic doOp(int op, logic [7:0] d);
    logic [3:0] idNow = refId();
    case (op)
      1: begin busWr = 1; busAddr = 3'd1; busWrData = d;
               mIer = d[3:0]; if (thrEmpty) mTx = 1; end
      2: begin busWr = 1; busAddr = 3'd0; busWrData = d; mTx = 0; end
      3: begin busRd = 1; busAddr = 3'd2; if (idNow == 4'h2) mTx = 0; end
      4: begin txEmptyEvt = 1; mTx = 1; end
      default: ;
    endcase
    @(negedge clk);
    busWr = 0; busRd = 0; txEmptyEvt = 0;
    @(negedge clk);
  endtask

  task automatic clearSrc();
    lineErr = 0; dataReady = 0; rxCount = 0; timeoutPend = 0; msDelta = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 iir", iirOut, 8'h01);
    chk("R1 ier", {4'd0, ierOut}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 upper bits dropped
    thrEmpty = 0;
    doOp(1, 8'hF0); checkAll("R2 upper");
    doOp(1, 8'hA5); checkAll("R2 low");

    // R10 / R3 latency: one clock
    doOp(1, 8'h04); checkAll("R11 idle");
    lineErr = 4'b0100;
    #1 chk("R10 before edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 after edge", {7'd0, irq}, 8'h01);
    chk("R3 line", iirOut, 8'h06);

    // R3 beats everything
    doOp(1, 8'h0F); timeoutPend = 1; dataReady = 1; msDelta = 4'h1; settle();
    checkAll("R3 top");

    // R4 timeout over rx, masked by bit0
    lineErr = 0; settle(); checkAll("R4 timeout");
    doOp(1, 8'h0E); checkAll("R4 masked");
    doOp(1, 8'h0F); clearSrc();

    // R5 FIFO boundary
    fifoEn = 1; trigLevel = 8; dataReady = 1; rxCount = 7; settle();
    checkAll("R5 below trig");
    chk("R9 fifo bits", {iirOut[7:4], 4'h0}, 8'hC0);
    rxCount = 8; settle(); checkAll("R5 at trig");
    fifoEn = 0; rxCount = 0; settle(); checkAll("R5 nonfifo");
    chk("R9 no fifo", {iirOut[7:4], 4'h0}, 8'h00);
    clearSrc(); settle();

    // R6 / R7 / R8 transmit empty
    msDelta = 4'h2;
    doOp(4, 0); checkAll("R6 tx over modem");
    doOp(3, 0); checkAll("R8 read clears");
    thrEmpty = 1; doOp(1, 8'h0F); checkAll("R7 ier rearm");
    doOp(2, 8'h55); checkAll("R7 thr clear");
    doOp(4, 0); lineErr = 4'h1; settle();
    doOp(3, 0); lineErr = 0; settle(); checkAll("R8 other id keeps");
    clearSrc(); settle();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 4);
      lineErr     = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0;
      timeoutPend = ($urandom_range(0, 4) == 0);
      dataReady   = $urandom_range(0, 1);
      rxCount     = CW'($urandom_range(0, 16));
      case ($urandom_range(0, 3))
        0: trigLevel = 1; 1: trigLevel = 4; 2: trigLevel = 8; default: trigLevel = 14;
      endcase
      msDelta  = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      fifoEn   = $urandom_range(0, 1);
      thrEmpty = $urandom_range(0, 1);
      settle();
      checkAll("R11 random");
      doOp(op, 8'($urandom));
      checkAll("R6 random op");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule